// File: doc/BRIEF.md
# Port-Width Transfer Splitter with Byte-Lane Steering

This block sits between an internal requester and an external device bus whose data path is 32 bits wide. An attached device may be wired as a full 32-bit port or as an 8-bit port. One internal access is a byte, a halfword, a word or a 16-byte line. The block turns that access into the run of external data beats that the selected port width needs. It places every byte on the correct byte lanes and generates the byte enables. For reads, it collects the returned bytes into one result.

The configuration inputs describe the target device and are sampled when a request is accepted:
- a port-size code;
- separate burst enables for reads and for writes;
- a lane-shift bit that puts narrow data at the top or the bottom of the bus;
- a mode bit that decides whether byte enables are also driven on reads.

Each beat is offered with a valid/ready handshake. After the last beat is accepted, the block returns one completion carrying the assembled read data. Cycle timing and address decode belong to other blocks.

Requests are assumed naturally aligned (a halfword on an even address, a word on a multiple of four). A line request may carry any address.

Top module: `xfer_splitter`

## Requirements
- R1: After reset, reqReady is 1 and beatValid and doneValid are 0; a request is accepted on a clock edge where reqValid and reqReady are both 1, and reqReady is 0 until the transfer's last beat has been accepted.
- R2: While beatValid is 1 and beatReady is 0, beatValid stays 1 and beatAddr, beatData, beatBe, beatBurst and beatLast hold their values.
- R3: reqSize encodes 0 = byte, 1 = halfword, 2 = word, 3 = line (16 bytes). Port code 01 selects an 8-bit port: there is one beat per transfer byte, and beatAddr starts at the transfer start and rises by 1. Any other code selects a 32-bit port: there is one beat for a byte, halfword or word, four beats for a line, and beatAddr rises by 4 per beat.
- R4: Byte order is big-endian. An N-byte write supplies its data in reqWdata[8N-1:0], with the lowest-addressed byte in bits 8N-1..8N-8. Beats carry bytes in ascending address order.
- R5: On an 8-bit port with cfgLaneShift = 0, the byte travels on lanes 31..24. With cfgLaneShift = 1 it travels on lanes 7..0. All other lanes of beatData are 0.
- R6: On a 32-bit port, the byte at address offset o (address bits 1..0) travels on lanes 31-8o..24-8o. A word, or each word of a line, uses all four lanes. Lanes carrying no transfer byte are 0, and beatData is 0 on reads.
- R7: beatBe bit i covers lanes 8i+7..8i and is set for each lane that carries a transfer byte. On writes, beatBe is always driven. On reads, beatBe is driven only when cfgBeMode is 1; otherwise it is 0.
- R8: beatBurst is 1 on every beat of a transfer that needs more than one beat, provided the enable for that direction is set (cfgBurstWr for writes, cfgBurstRd for reads). Otherwise it is 0. The beat count does not depend on the enables.
- R9: A line transfer always starts at the request address with its low four bits cleared.
- R10: doneValid is 1 for exactly one cycle, in the cycle after the last beat is accepted. For a read, doneRdata then holds all bytes in the R4 format, with the byte from the lowest address in the most significant used position.
- R11: beatWrite equals the direction of the accepted request for all of its beats.
- R12: beatLast is 1 only on the final beat of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Internal request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Request byte address |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 line |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 128 | Write data, right-justified, big-endian |
| cfgPortSize | input | 2 | 01 = 8-bit port, other = 32-bit port |
| cfgBurstRd | input | 1 | Burst enable for reads |
| cfgBurstWr | input | 1 | Burst enable for writes |
| cfgLaneShift | input | 1 | Narrow lane: 0 top, 1 bottom |
| cfgBeMode | input | 1 | 1 = byte enables on reads too |
| beatValid | output | 1 | External beat offered |
| beatReady | input | 1 | External side takes the beat |
| beatAddr | output | ADDR_W | Beat byte address |
| beatWrite | output | 1 | Beat direction |
| beatBurst | output | 1 | Beat belongs to a burst |
| beatLast | output | 1 | Final beat of the transfer |
| beatData | output | 32 | Steered write data |
| beatBe | output | 4 | Byte enables per lane |
| beatRdata | input | 32 | Read data returned for the beat |
| doneValid | output | 1 | Transfer complete (one cycle) |
| doneRdata | output | 128 | Assembled read data, right-justified |

## Verification
Every transfer size is driven on both port widths, including byte reads at all four word offsets on the 32-bit port. These offset reads separate the lane-extraction paths from one another. Narrow transfers are run with both lane-shift settings, and the unused lanes of the returned read data hold a junk pattern, so taking the wrong lane corrupts the result. Each direction is run with its own burst enable on and off, and a read is also run with only the write enable set, which shows whether the burst flag follows the request's direction. Line requests use unaligned addresses to expose a missing alignment step, and a stalling ready pattern exposes beats that change or advance while waiting.

// File: rtl/xfer_split_pkg.sv
package xfer_split_pkg;
  localparam int LINE_BYTES = 16;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int IDX_W      = $clog2(LINE_BYTES);
  localparam int LANES      = 4;
  localparam int BUS_W      = LANES * 8;
  localparam logic [1:0] PORT_NARROW = 2'b01;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LINE = 2'd3
  } xferSize_e;

  // strobes and beat context from control to datapath
  typedef struct packed {
    logic             active;
    logic             load;
    logic             capture;
    logic             isWrite;
    logic             narrow;
    logic             laneShift;
    logic             beMode;
    xferSize_e        size;
    logic [1:0]       offset;
    logic [IDX_W-1:0] beatIdx;
  } ctrlStrobe_t;

  function automatic int bytesFor(logic [1:0] s);
    return (s == 2'd3) ? LINE_BYTES : (1 << s);
  endfunction
endpackage

// File: rtl/xfer_split_ctrl.sv
module xfer_split_ctrl
  import xfer_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [1:0]        cfgPortSize,
  input  logic              cfgBurstRd,
  input  logic              cfgBurstWr,
  input  logic              cfgLaneShift,
  input  logic              cfgBeMode,
  output logic              beatValid,
  input  logic              beatReady,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              beatWrite,
  output logic              beatBurst,
  output logic              beatLast,
  output logic              doneValid,
  output ctrlStrobe_t       strb
);
  logic busy, narrowQ, shiftQ, beModeQ, writeQ, burstEnQ;
  xferSize_e sizeQ;
  logic [IDX_W-1:0] beatIdx, lastIdx;
  logic [ADDR_W-1:0] startAddr;
  logic accept, beatFire, lastBeat, reqNarrow;

  function automatic logic [IDX_W-1:0] lastIdxFor(logic [1:0] sz, logic nar);
    if (nar) return (sz == SZ_LINE) ? IDX_W'(LINE_BYTES - 1) : IDX_W'((1 << sz) - 1);
    return (sz == SZ_LINE) ? IDX_W'(LINE_BYTES / LANES - 1) : '0;
  endfunction

  assign reqReady  = !busy;
  assign accept    = reqValid && reqReady;
  assign beatFire  = busy && beatReady;
  assign lastBeat  = (beatIdx == lastIdx);
  assign reqNarrow = (cfgPortSize == PORT_NARROW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      doneValid <= 1'b0;
      beatIdx   <= '0;
      lastIdx   <= '0;
      startAddr <= '0;
      narrowQ   <= 1'b0;
      shiftQ    <= 1'b0;
      beModeQ   <= 1'b0;
      writeQ    <= 1'b0;
      burstEnQ  <= 1'b0;
      sizeQ     <= SZ_BYTE;
    end else begin
      doneValid <= beatFire && lastBeat;
      if (accept) begin
        busy      <= 1'b1;
        beatIdx   <= '0;
        lastIdx   <= lastIdxFor(reqSize, reqNarrow);
        startAddr <= (reqSize == SZ_LINE) ? {reqAddr[ADDR_W-1:IDX_W], IDX_W'(0)} : reqAddr;
        narrowQ   <= reqNarrow;
        shiftQ    <= cfgLaneShift;
        beModeQ   <= cfgBeMode;
        writeQ    <= reqWrite;
        burstEnQ  <= reqWrite ? cfgBurstWr : cfgBurstRd;
        sizeQ     <= xferSize_e'(reqSize);
      end else if (beatFire) begin
        if (lastBeat) busy <= 1'b0;
        else          beatIdx <= beatIdx + 1'b1;
      end
    end
  end

  assign beatValid = busy;
  assign beatAddr  = startAddr + (narrowQ ? ADDR_W'(beatIdx) : (ADDR_W'(beatIdx) << 2));
  assign beatWrite = busy && writeQ;
  assign beatBurst = busy && burstEnQ && (lastIdx != '0);
  assign beatLast  = busy && lastBeat;

  always_comb begin
    strb.active    = busy;
    strb.load      = accept;
    strb.capture   = beatFire && !writeQ;
    strb.isWrite   = writeQ;
    strb.narrow    = narrowQ;
    strb.laneShift = shiftQ;
    strb.beMode    = beModeQ;
    strb.size      = sizeQ;
    strb.offset    = startAddr[1:0];
    strb.beatIdx   = beatIdx;
  end

  // R2: a stalled beat keeps its address and position
  p_hold_beat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatReady) |=> (beatValid && $stable(beatAddr) && $stable(beatLast)));

  // R3: consecutive beats step by the port width
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatReady && !beatLast) |=>
      (beatAddr == $past(beatAddr) + (narrowQ ? ADDR_W'(1) : ADDR_W'(LANES))));

  // R9: first beat of a line is line aligned
  p_line_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatIdx == '0 && sizeQ == SZ_LINE) |-> (beatAddr[IDX_W-1:0] == '0));

  // R10: completion only right after the last beat is taken
  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(beatValid && beatReady && beatLast));
endmodule

// File: rtl/xfer_split_dpath.sv
module xfer_split_dpath
  import xfer_split_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] reqWdata,
  input  logic [BUS_W-1:0]  beatRdata,
  output logic [BUS_W-1:0]  beatData,
  output logic [LANES-1:0]  beatBe,
  output logic [LINE_W-1:0] doneRdata
);
  // one register carries write data out and gathers read data in,
  // left-justified so transfer byte k sits at bits LINE_W-1-8k
  logic [LINE_W-1:0] holdQ;
  logic [LANES-1:0]  laneAct;
  logic [IDX_W-1:0]  laneIdx [LANES];

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic act;
    logic [IDX_W-1:0] idx;
    always_comb begin
      int k;
      if (strb.narrow) begin
        act = (L == (strb.laneShift ? 0 : LANES - 1));
        k   = int'(strb.beatIdx);
      end else begin
        k   = int'(strb.beatIdx) * LANES + (LANES - 1 - L) - int'(strb.offset);
        act = (k >= 0) && (k < bytesFor(strb.size));
      end
      idx = act ? IDX_W'(k) : '0;
    end
    assign laneAct[L] = act;
    assign laneIdx[L] = idx;
    assign beatData[8*L +: 8] = (strb.active && act && strb.isWrite) ?
                                holdQ[LINE_W - 1 - 8*idx -: 8] : 8'h00;
    assign beatBe[L] = strb.active && act && (strb.isWrite || strb.beMode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (strb.load) begin
      holdQ <= reqWrite ? (reqWdata << (8 * (LINE_BYTES - bytesFor(reqSize)))) : '0;
    end else if (strb.capture) begin
      for (int L = 0; L < LANES; L++)
        if (laneAct[L]) holdQ[LINE_W - 1 - 8*laneIdx[L] -: 8] <= beatRdata[8*L +: 8];
    end
  end

  assign doneRdata = holdQ >> (8 * (LINE_BYTES - bytesFor(strb.size)));

  // R5: narrow beats use only the selected lane
  p_narrow_lane_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && strb.narrow) |->
      ($onehot0(beatBe) &&
       ((beatData & ~(strb.laneShift ? 32'h0000_00FF : 32'hFF00_0000)) == '0)));

  // R7: reads in write-only enable mode drive no byte enables
  p_read_be_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.isWrite && !strb.beMode) |-> (beatBe == '0));

  // R6: read beats drive no data
  p_read_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.isWrite) |-> (beatData == '0));
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
  import xfer_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] reqWdata,
  input  logic [1:0]        cfgPortSize,
  input  logic              cfgBurstRd,
  input  logic              cfgBurstWr,
  input  logic              cfgLaneShift,
  input  logic              cfgBeMode,
  output logic              beatValid,
  input  logic              beatReady,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              beatWrite,
  output logic              beatBurst,
  output logic              beatLast,
  output logic [BUS_W-1:0]  beatData,
  output logic [LANES-1:0]  beatBe,
  input  logic [BUS_W-1:0]  beatRdata,
  output logic              doneValid,
  output logic [LINE_W-1:0] doneRdata
);
  ctrlStrobe_t strb;

  xfer_split_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite),
    .cfgPortSize(cfgPortSize), .cfgBurstRd(cfgBurstRd), .cfgBurstWr(cfgBurstWr),
    .cfgLaneShift(cfgLaneShift), .cfgBeMode(cfgBeMode),
    .beatValid(beatValid), .beatReady(beatReady), .beatAddr(beatAddr),
    .beatWrite(beatWrite), .beatBurst(beatBurst), .beatLast(beatLast),
    .doneValid(doneValid), .strb(strb)
  );

  xfer_split_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .beatRdata(beatRdata), .beatData(beatData), .beatBe(beatBe),
    .doneRdata(doneRdata)
  );
endmodule

// File: tb/xfer_splitter_bench.sv
module xfer_splitter_bench;
  import xfer_split_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0] reqSize = '0, cfgPortSize = '0;
  logic [LINE_W-1:0] reqWdata = '0;
  logic cfgBurstRd = 0, cfgBurstWr = 0, cfgLaneShift = 0, cfgBeMode = 0;
  logic beatValid, beatWrite, beatBurst, beatLast, doneValid;
  logic beatReady = 1'b0;
  logic [ADDR_W-1:0] beatAddr;
  logic [BUS_W-1:0] beatData, beatRdata = '0;
  logic [LANES-1:0] beatBe;
  logic [LINE_W-1:0] doneRdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_splitter u_xfer_splitter (.*);

  typedef struct {
    logic [31:0] addr; logic [31:0] data; logic [3:0] be;
    logic wr; logic burst; logic last;
  } beat_t;

  beat_t beatQ[$];
  logic [LINE_W-1:0] doneQ[$];
  bit doneRdQ[$];
  int total = 0, bad = 0, doneSeen = 0, tick = 0;

  task automatic chk(input bit ok, input string tag, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // driver: builds the expected beats and completion, then issues the request
  task automatic doXfer(input logic [31:0] addr, input logic [1:0] size, input bit wr,
                        input logic [LINE_W-1:0] wdata, input logic [1:0] port,
                        input bit shift, input bit bw, input bit br, input bit bem);
    int nB, nBeats, target;
    bit narrow, en;
    logic [31:0] st;
    logic [LINE_W-1:0] expRd;
    nB = (size == 2'd3) ? 16 : (1 << size);
    st = (size == 2'd3) ? {addr[31:4], 4'h0} : addr;
    narrow = (port == 2'b01);
    nBeats = narrow ? nB : ((size == 2'd3) ? 4 : 1);
    en = wr ? bw : br;
    expRd = '0;
    for (int i = 0; i < nBeats; i++) begin
      beat_t b;
      int kLo, kHi;
      b.addr = narrow ? st + i : st + 4 * i;
      b.data = '0; b.be = '0; b.wr = wr;
      b.burst = en && (nBeats > 1);
      b.last = (i == nBeats - 1);
      kLo = narrow ? i : i * 4;
      kHi = narrow ? i : ((i * 4 + 3 < nB - 1) ? i * 4 + 3 : nB - 1);
      for (int k = kLo; k <= kHi; k++) begin
        int lane;
        lane = narrow ? (shift ? 0 : 3) : 3 - int'((st + k) & 32'd3);
        if (wr) b.data[8*lane +: 8] = wdata[8*(nB-1-k) +: 8];
        if (wr || bem) b.be[lane] = 1'b1;
      end
      beatQ.push_back(b);
    end
    for (int k = 0; k < nB; k++) expRd[8*(nB-1-k) +: 8] = memByte(st + k);
    doneQ.push_back(expRd);
    doneRdQ.push_back(!wr);
    target = doneSeen + 1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready while idle", LINE_W'(reqReady), 1);
    reqAddr = addr; reqSize = size; reqWrite = wr; reqWdata = wdata;
    cfgPortSize = port; cfgLaneShift = shift; cfgBurstWr = bw; cfgBurstRd = br; cfgBeMode = bem;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R1 busy after accept", LINE_W'(reqReady), 0);
    wait (doneSeen >= target);
    @(negedge clk);
  endtask

  // monitor / responder
  initial begin
    bit stalled = 0;
    logic [31:0] snapAddr = '0, snapData = '0;
    logic [3:0] snapBe = '0;
    logic snapLast = 0, snapBurst = 0;
    forever begin
      @(negedge clk);
      if (stalled) begin
        chk(beatValid && beatAddr == snapAddr && beatData == snapData && beatBe == snapBe &&
            beatLast == snapLast && beatBurst == snapBurst,
            "R2 stalled beat held", LINE_W'(beatAddr), LINE_W'(snapAddr));
      end
      if (beatValid) begin
        bit rdy;
        rdy = (tick % 3) != 1;
        tick++;
        if (rdy) begin
          if (beatQ.size() == 0) begin
            chk(0, "R12 unexpected extra beat", LINE_W'(beatAddr), 0);
          end else begin
            beat_t e;
            e = beatQ.pop_front();
            chk(beatAddr == e.addr, "R3/R9 beat address", LINE_W'(beatAddr), LINE_W'(e.addr));
            chk(beatData == e.data, "R4/R5/R6 beat lane data", LINE_W'(beatData), LINE_W'(e.data));
            chk(beatBe == e.be, "R7 byte enables", LINE_W'(beatBe), LINE_W'(e.be));
            chk(beatBurst == e.burst, "R8 burst flag", LINE_W'(beatBurst), LINE_W'(e.burst));
            chk(beatLast == e.last, "R12 last flag", LINE_W'(beatLast), LINE_W'(e.last));
            chk(beatWrite == e.wr, "R11 beat direction", LINE_W'(beatWrite), LINE_W'(e.wr));
          end
          if (cfgPortSize == 2'b01) begin
            beatRdata = 32'hEEEE_EEEE;
            if (cfgLaneShift) beatRdata[7:0] = memByte(beatAddr);
            else beatRdata[31:24] = memByte(beatAddr);
          end else begin
            logic [31:0] w;
            w = {beatAddr[31:2], 2'b00};
            beatRdata = {memByte(w), memByte(w + 1), memByte(w + 2), memByte(w + 3)};
          end
        end
        beatReady = rdy;
        stalled = !rdy;
        snapAddr = beatAddr; snapData = beatData; snapBe = beatBe;
        snapLast = beatLast; snapBurst = beatBurst;
      end else begin
        beatReady = 1'b0;
        stalled = 0;
      end
      if (doneValid) begin
        if (doneQ.size() == 0) begin
          chk(0, "R10 unexpected completion", LINE_W'(doneValid), 0);
        end else begin
          logic [LINE_W-1:0] ex;
          bit isRd;
          ex = doneQ.pop_front();
          isRd = doneRdQ.pop_front();
          if (isRd) chk(doneRdata == ex, "R10 assembled read data", doneRdata, ex);
          else chk(1, "R10 write completion", 0, 0);
        end
        doneSeen++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL R10 watchdog actual=hang expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1 && beatValid == 1'b0 && doneValid == 1'b0, "R1 reset state",
        LINE_W'({reqReady, beatValid, doneValid}), LINE_W'(3'b100));
    rstN = 1'b1;
    @(negedge clk);
    // narrow word writes: non-burst, then burst
    doXfer(32'h0000_1000, 2'd2, 1, 128'h11223344, 2'b01, 0, 0, 0, 0);
    doXfer(32'h0000_2004, 2'd2, 1, 128'hA1B2C3D4, 2'b01, 0, 1, 0, 0);
    // narrow word read, bottom lane, burst, no read enables
    doXfer(32'h0000_3008, 2'd2, 0, '0, 2'b01, 1, 0, 1, 0);
    // narrow halfword read, top lane, non-burst, enables on reads
    doXfer(32'h0000_400A, 2'd1, 0, '0, 2'b01, 0, 0, 0, 1);
    // narrow byte write, bottom lane
    doXfer(32'h0000_5003, 2'd0, 1, 128'h5A, 2'b01, 1, 1, 1, 0);
    // wide byte reads at every offset
    for (int o = 0; o < 4; o++)
      doXfer(32'h0000_6010 + o, 2'd0, 0, '0, 2'b00, 0, 1, 1, 1);
    // wide halfword write at offset 2, and at offset 0
    doXfer(32'h0000_7002, 2'd1, 1, 128'hBEEF, 2'b00, 0, 1, 1, 0);
    doXfer(32'h0000_7100, 2'd1, 1, 128'hCAFE, 2'b00, 0, 0, 0, 0);
    // wide word write and read
    doXfer(32'h0000_8004, 2'd2, 1, 128'hDEAD_0001, 2'b00, 0, 1, 1, 0);
    doXfer(32'h0000_8104, 2'd2, 0, '0, 2'b00, 0, 0, 0, 1);
    // wide line reads from an unaligned address, burst on and off
    doXfer(32'h1234_5678, 2'd3, 0, '0, 2'b00, 0, 0, 1, 1);
    doXfer(32'h0000_9ABC, 2'd3, 0, '0, 2'b00, 0, 0, 0, 0);
    // read with only the write burst enable set: no burst
    doXfer(32'h0000_A000, 2'd3, 0, '0, 2'b00, 0, 1, 0, 0);
    // narrow line write, unaligned, burst; narrow line read bottom lane
    doXfer(32'h0000_B00D, 2'd3, 1, 128'h00112233_44556677_8899AABB_CCDDEEFF, 2'b01, 0, 1, 0, 1);
    doXfer(32'h0000_C007, 2'd3, 0, '0, 2'b01, 1, 0, 1, 0);
    // port code 10 behaves as a 32-bit port
    doXfer(32'h0000_D00C, 2'd2, 0, '0, 2'b10, 0, 0, 1, 1);
    chk(beatQ.size() == 0, "R3 all beats issued", LINE_W'(beatQ.size()), 0);
    chk(doneQ.size() == 0, "R10 all completions seen", LINE_W'(doneQ.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule